// File: doc/BRIEF.md
# Wraparound Bit-Mask Generator Unit

This execution unit serves one register instruction on a 32-bit datapath whose bit positions are counted from the most significant end (position 0 is the MSB). Each cycle it decodes the presented instruction word. When the word names the mask-generate operation, the unit takes the low five bits of the first source value as a start position and the low five bits of the second as an end position. It then produces a 32-bit mask for the destination register.

When start is at or below end, the mask is a run of ones covering start through end. When start sits exactly one past end, every bit is set. When start lies further out, the range wraps around: a hole of zeros fills positions end+1 through start-1 and every other bit is one. If the instruction's record bit is set, the unit also emits a 4-bit condition field. Its sign bits come from comparing the result with zero, and its overflow-summary bit is copied from an input flag. All results are registered and appear one clock after the inputs.

Top module: `mg_unit`

## Requirements
- R1: `valid_o` is high one cycle after an instruction word whose bits [31:26] equal 31 and bits [10:1] equal 29. For any other word, `valid_o` and `cr_we_o` are low in that cycle.
- R2: `rd_idx_o` carries instruction bits [20:16], the destination field, registered with `valid_o`.
- R3: Only bits [4:0] of `rs_val_i` (start) and of `rb_val_i` (end) affect the mask. All upper bits are ignored.
- R4: If start <= end, mask positions start..end are one and all others zero, where position p is vector bit 31-p.
- R5: If start == end+1, the mask is all ones.
- R6: If start > end+1, positions end+1..start-1 are zero and all others one.
- R7: end+1 is formed at 6 bits, so end=31 never wraps: any start gives a run of ones from start through position 31.
- R8: When the record bit (instruction bit 0) is one on a valid instruction, `cr_we_o` is high and `cr_o` = {LT,GT,EQ,SO}. LT, GT and EQ come from a signed comparison of the mask with zero, and exactly one of them is set.
- R9: The SO bit, `cr_o[0]`, equals `so_i` sampled with the instruction.
- R10: When the record bit is zero, `cr_we_o` stays low while `valid_o` is high.
- R11: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Source value holding the start position |
| rb_val_i | input | 32 | Source value holding the end position |
| so_i | input | 1 | Summary-overflow flag from the exception register |
| valid_o | output | 1 | Destination write enable |
| rd_idx_o | output | 5 | Destination register index |
| rd_data_o | output | 32 | Generated mask |
| cr_we_o | output | 1 | Condition-field update enable |
| cr_o | output | 4 | Condition field {LT,GT,EQ,SO} |

## Verification
Mask generation and the condition-field update fall in the same cycle whenever the record form is issued. The bench sweeps every start/end pair twice, once with the record bit clear and once with it set, and toggles `so_i` along the way. In each cycle it compares the mask with a shift-based arithmetic model. In the record cycles it also checks that the condition bits agree with the sign of that same mask and that SO follows the flag. Non-matching opcodes are interleaved to show that neither enable rises for them.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam logic [5:0] PRI_OP = 6'd31;
  localparam logic [9:0] EXT_OP = 10'd29;

  typedef struct packed {
    logic                 hit;
    logic                 rec;
    logic [REG_IDX_W-1:0] rt;
  } mg_dec_t;
endpackage

// File: rtl/mg_decode.sv
module mg_decode
  import mg_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output mg_dec_t            dec_o
);
  // fields counted from MSB: opcode 0-5, dest 11-15, xop 21-30, rec 31
  always_comb begin
    dec_o.hit = (instr_i[31:26] == PRI_OP) && (instr_i[10:1] == EXT_OP);
    dec_o.rec = instr_i[0];
    dec_o.rt  = instr_i[20:16];
  end
endmodule

// File: rtl/mg_mask_gen.sv
module mg_mask_gen #(
  parameter int unsigned XLEN  = 32,
  localparam int unsigned POS_W = $clog2(XLEN)
) (
  input  logic [POS_W-1:0] start_i,
  input  logic [POS_W-1:0] end_i,
  output logic [XLEN-1:0]  mask_o
);
  logic [POS_W:0] end_p1;
  logic           wrap;

  assign end_p1 = {1'b0, end_i} + 1'b1;
  assign wrap   = {1'b0, start_i} >= end_p1;

  for (genvar g = 0; g < XLEN; g++) begin : g_bit
    localparam logic [POS_W-1:0] PIDX = POS_W'(g);
    logic ge_s, le_e;
    assign ge_s = PIDX >= start_i;
    assign le_e = PIDX <= end_i;
    // position g lives at vector bit XLEN-1-g
    assign mask_o[XLEN-1-g] = wrap ? (ge_s | le_e) : (ge_s & le_e);
  end
endmodule

// File: rtl/mg_cond.sv
module mg_cond #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] res_i,
  input  logic            so_i,
  output logic [3:0]      cr_o
);
  logic lt, eq, gt;
  assign lt   = res_i[XLEN-1];
  assign eq   = (res_i == '0);
  assign gt   = !lt && !eq;
  assign cr_o = {lt, gt, eq, so_i};
endmodule

// File: rtl/mg_unit.sv
module mg_unit
  import mg_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  localparam int unsigned POS_W = $clog2(XLEN)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [XLEN-1:0]      rs_val_i,
  input  logic [XLEN-1:0]      rb_val_i,
  input  logic                 so_i,
  output logic                 valid_o,
  output logic [REG_IDX_W-1:0] rd_idx_o,
  output logic [XLEN-1:0]      rd_data_o,
  output logic                 cr_we_o,
  output logic [3:0]           cr_o
);
  mg_dec_t         dec;
  logic [XLEN-1:0] mask;
  logic [3:0]      cr_d;

  mg_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  mg_mask_gen #(.XLEN(XLEN)) u_mask (
    .start_i(rs_val_i[POS_W-1:0]),
    .end_i  (rb_val_i[POS_W-1:0]),
    .mask_o (mask)
  );

  mg_cond #(.XLEN(XLEN)) u_cond (.res_i(mask), .so_i(so_i), .cr_o(cr_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      rd_idx_o  <= '0;
      rd_data_o <= '0;
      cr_we_o   <= 1'b0;
      cr_o      <= '0;
    end else begin
      valid_o   <= dec.hit;
      rd_idx_o  <= dec.rt;
      rd_data_o <= mask;
      cr_we_o   <= dec.hit && dec.rec;
      cr_o      <= cr_d;
    end
  end

  p_no_we_bad_op_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(instr_i[31:26]) != PRI_OP) |-> (!valid_o && !cr_we_o));
  p_mask_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (rd_data_o != '0));
  p_equal_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rs_val_i[POS_W-1:0] == rb_val_i[POS_W-1:0] + 1'b1) && (rb_val_i[POS_W-1:0] != '1))
    |=> (rd_data_o == '1));
  p_cmp_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> ($countones(cr_o[3:1]) == 1));
  p_so_copy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> (cr_o[0] == $past(so_i)));
  p_rec_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(instr_i[0]) |-> !cr_we_o);
  p_we_needs_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> valid_o);
endmodule

// File: tb/sim_mg_unit.sv
module sim_mg_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = '0, rs_val_i = '0, rb_val_i = '0;
  logic        so_i = 1'b0;
  logic        valid_o, cr_we_o;
  logic [4:0]  rd_idx_o;
  logic [31:0] rd_data_o;
  logic [3:0]  cr_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  mg_unit u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input int s, input int e);
    logic [63:0] ones = 64'hFFFF_FFFF;
    if (s <= e) return 32'(((ones >> s) & (ones << (31 - e))));
    if (s == e + 1) return 32'hFFFF_FFFF;
    return ~32'(((ones >> (e + 1)) & (ones << (32 - s))));
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] ra, input logic rc);
    return {6'd31, 5'd3, ra, 5'd7, 10'd29, rc};
  endfunction

  task automatic run(input logic [31:0] ins, input logic [31:0] rs, input logic [31:0] rb,
                     input logic so);
    @(negedge clk_i);
    instr_i = ins; rs_val_i = rs; rb_val_i = rb; so_i = so;
    @(negedge clk_i);
  endtask

  initial begin
    #1;
    chk("R11 valid", valid_o, 0);
    chk("R11 data", rd_data_o, 0);
    chk("R11 cr", {cr_we_o, cr_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // stated examples
    run(mk(5'd6, 1'b0), 32'h10, 32'h14, 1'b0);
    chk("R4 example", rd_data_o, 32'h0000F800);
    chk("R10 no cr", cr_we_o, 0);
    run(mk(5'd6, 1'b1), 32'h17, 32'h10, 1'b0);
    chk("R6 example", rd_data_o, 32'hFFFF81FF);
    chk("R8 example", {cr_we_o, cr_o}, 5'b11000);
    // full sweep, both record settings
    for (int rc = 0; rc < 2; rc++) begin
      for (int s = 0; s < 32; s++) begin
        for (int e = 0; e < 32; e++) begin
          logic [31:0] exp_m, rs, rb;
          logic so;
          logic [4:0] ra;
          ra = 5'(s + e);
          so = 1'((s ^ e) & 1);
          rs = {$urandom() & 32'hFFFF_FFE0} | 32'(s);  // R3 upper bits random
          rb = {$urandom() & 32'hFFFF_FFE0} | 32'(e);
          exp_m = model(s, e);
          run(mk(ra, 1'(rc)), rs, rb, so);
          if (s <= e && e == 31) chk("R7 end31", rd_data_o, exp_m);
          else if (s <= e) chk("R4 run", rd_data_o, exp_m);
          else if (s == e + 1) chk("R5 full", rd_data_o, exp_m);
          else chk("R6 hole", rd_data_o, exp_m);
          chk("R3 ignore upper", rd_data_o, model(s, e));
          chk("R1 valid", valid_o, 1);
          chk("R2 idx", rd_idx_o, ra);
          if (rc == 1) begin
            logic lt, eq;
            lt = exp_m[31]; eq = (exp_m == 0);
            chk("R8 cr", {cr_we_o, cr_o[3:1]}, {1'b1, lt, !lt && !eq, eq});
            chk("R9 so", cr_o[0], so);
          end else begin
            chk("R10 no cr", cr_we_o, 0);
          end
        end
        // interleave a non-matching word
        run({6'(s == 31 ? 0 : s), 5'd1, 5'd2, 5'd3, 10'd29, 1'b1}, 32'h0, 32'h5, 1'b1);
        chk("R1 bad pri", {valid_o, cr_we_o}, 0);
        run({6'd31, 5'd1, 5'd2, 5'd3, 10'(s == 29 ? 28 : 300 + s), 1'b1}, 32'h0, 32'h5, 1'b1);
        chk("R1 bad ext", {valid_o, cr_we_o}, 0);
      end
    end
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R11 reset again", {valid_o, cr_we_o, rd_data_o}, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule